// File: doc/BRIEF.md
# Flash Tick Phase Sequencer

This block paces one compute tick of a tile array that shares a lane bus with a host. After an accepted start request it steps through setup, read, bus turnaround, write and readout-sample phases. An optional interphase auto-reset phase may follow. Each phase lasts for a programmable number of clock cycles. The block owns the bus direction: the host keeps the lanes through setup and read, nobody drives them during turnaround, and only then does the array get its write enable. The lane arithmetic, the summing and the tile state all live outside. This block gives only the phase code, the enables and the hold window that the surrounding logic keys on.

A start is honoured only while the sequencer is idle and the configuration has been applied. Domain-reset and configuration-load requests are honoured only between ticks. A refused request produces a one-cycle reject pulse. During the write phase the block collects overflow and collision reports. At the end of the readout sample it latches them into a 32-bit status word, together with the auto-reset mask built from the per-domain fire counts. The mask is presented only during the auto-reset phase, which comes after that latch.

Top module: `tick_sequencer`

## Requirements
- R1: `phase_o` encodes 0 idle, 1 setup, 2 read, 3 turnaround, 4 write, 5 readout sample, 6 auto-reset. An accepted tick visits setup, read, turnaround, write and sample in that order. It then enters auto-reset if `autorst_en_i` was 1 when the tick was accepted, and otherwise returns to idle.
- R2: Each phase lasts for its length input in cycles, and a length of 0 counts as 1. The lengths and the auto-reset enable are captured in the cycle the start is accepted. Changing them during a tick has no effect on that tick.
- R3: `host_drive_o` is 1 in idle, setup and read and 0 otherwise. `array_drive_o` is 1 only in write. The two are never 1 together, and the array enable can only rise after a turnaround cycle.
- R4: `hold_o` (input lanes must stay stable) is 1 exactly during setup and read.
- R5: A start request is accepted when the block is idle and `params_applied_i` is 1, and setup begins in the next cycle. A start request under any other condition is dropped, and `start_rej_o` is 1 in the next cycle.
- R6: A domain-reset or configuration-load request raises its go pulse in the next cycle if the block is idle and no start is accepted in the same cycle. Otherwise the request is dropped and `cmd_rej_o` is 1 in the next cycle.
- R7: At the end of the sample phase `status_o` is loaded with bit 0 = 1 (tick completed). Bit 1 is the OR of `ovf_i` and bit 2 is the OR of `collide_i`, each sampled over the write cycles of this tick only. Bits 31..3 are zero. The value holds until the next tick's sample phase ends.
- R8: `autorst_mask_o` is zero outside the auto-reset phase. During auto-reset it equals the OR of the winner masks of every domain whose fire count is nonzero, as sampled at the end of the sample phase.
- R9: `busy_o` is 1 whenever `phase_o` is not idle.
- R10: After reset: phase idle, host drive 1, array drive 0, status zero, and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Tick start request |
| params_applied_i | input | 1 | Configuration has been applied |
| dom_rst_req_i | input | 1 | Domain-reset command request |
| param_load_req_i | input | 1 | Configuration-load command request |
| len_setup_i | input | CNT_W | Setup length in cycles |
| len_read_i | input | CNT_W | Read length in cycles |
| len_turn_i | input | CNT_W | Turnaround length in cycles |
| len_write_i | input | CNT_W | Write length in cycles |
| len_sample_i | input | CNT_W | Readout-sample length in cycles |
| len_autorst_i | input | CNT_W | Auto-reset length in cycles |
| autorst_en_i | input | 1 | Run the auto-reset phase in this tick |
| ovf_i | input | 1 | Overflow report from the bus summer |
| collide_i | input | 1 | Collision report from the bus summer |
| fire_cnt_i | input | N_DOM*FC_W | Per-domain fire counts, domain d at bits d*FC_W |
| winner_mask_i | input | N_DOM*MASK_W | Reset mask of each domain's winner, domain d at bits d*MASK_W |
| phase_o | output | 3 | Current phase code |
| busy_o | output | 1 | Tick in progress |
| hold_o | output | 1 | Input lanes must be held stable |
| host_drive_o | output | 1 | Host may drive the lane bus |
| array_drive_o | output | 1 | Array may drive the lane bus |
| start_rej_o | output | 1 | Start request was dropped |
| dom_rst_go_o | output | 1 | Domain reset accepted |
| param_load_go_o | output | 1 | Configuration load accepted |
| cmd_rej_o | output | 1 | Command request was dropped |
| status_o | output | 32 | Status word of the last completed tick |
| autorst_mask_o | output | MASK_W | Auto-reset domain mask |

## Verification
The phase sequence is swept over a grid of phase lengths that includes zero, one and several cycles, with the auto-reset phase both on and off. This separates the zero-as-one rule, off-by-one counter faults and a skipped auto-reset. Each tick drives overflow and collision reports only on write cycles, in all four combinations, and holds them high in every other phase. A status word that reads zero where one is expected shows a lost write-phase report, and a stray one shows that reports from other phases leak in. The fire counts and winner masks change from tick to tick, so domains with zero and nonzero counts are mixed. Start and command requests are tried while idle, in the middle of a tick, while the configuration is not applied, and in the same cycle as an accepted start.

// File: rtl/tick_seq_pkg.sv
package tick_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_READ    = 3'd2,
    PH_TURN    = 3'd3,
    PH_WRITE   = 3'd4,
    PH_SAMPLE  = 3'd5,
    PH_AUTORST = 3'd6
  } phase_e;

  localparam int unsigned NUM_LEN = 6;
endpackage

// File: rtl/tick_cmd_gate.sv
module tick_cmd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic start_i,
  input  logic applied_i,
  input  logic dom_rst_req_i,
  input  logic load_req_i,
  output logic start_go_o,
  output logic start_rej_o,
  output logic dom_rst_go_o,
  output logic load_go_o,
  output logic cmd_rej_o
);
  logic start_ok;
  logic cmd_window;
  logic start_rej_d, dom_go_d, load_go_d, cmd_rej_d;
  logic start_rej_q, dom_go_q, load_go_q, cmd_rej_q;

  always_comb begin
    start_ok    = start_i & idle_i & applied_i;
    cmd_window  = idle_i & ~start_ok;
    start_rej_d = start_i & ~start_ok;
    dom_go_d    = dom_rst_req_i & cmd_window;
    load_go_d   = load_req_i & cmd_window;
    cmd_rej_d   = (dom_rst_req_i | load_req_i) & ~cmd_window;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_rej_q <= 1'b0;
      dom_go_q    <= 1'b0;
      load_go_q   <= 1'b0;
      cmd_rej_q   <= 1'b0;
    end else begin
      start_rej_q <= start_rej_d;
      dom_go_q    <= dom_go_d;
      load_go_q   <= load_go_d;
      cmd_rej_q   <= cmd_rej_d;
    end
  end

  assign start_go_o   = start_ok;
  assign start_rej_o  = start_rej_q;
  assign dom_rst_go_o = dom_go_q;
  assign load_go_o    = load_go_q;
  assign cmd_rej_o    = cmd_rej_q;

  // R5: a reject pulse always follows an actual start request
  assert_start_rej_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej_o |-> $past(start_i));
  // R6: commands go through only from an idle cycle
  assert_cmd_idle_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_rst_go_o | load_go_o) |-> $past(idle_i));
endmodule

// File: rtl/tick_phase_fsm.sv
module tick_phase_fsm
  import tick_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_go_i,
  input  logic [NUM_LEN*CNT_W-1:0]   lens_i,
  input  logic                       autorst_en_i,
  output phase_e                     phase_o,
  output logic                       last_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q [NUM_LEN];
  logic             ar_en_q;
  logic             phase_end;

  function automatic phase_e follow(input phase_e p, input logic ar);
    case (p)
      PH_SETUP:  follow = PH_READ;
      PH_READ:   follow = PH_TURN;
      PH_TURN:   follow = PH_WRITE;
      PH_WRITE:  follow = PH_SAMPLE;
      PH_SAMPLE: follow = ar ? PH_AUTORST : PH_IDLE;
      default:   follow = PH_IDLE;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] start_count(input logic [CNT_W-1:0] l);
    start_count = (l == '0) ? '0 : l - 1'b1;
  endfunction

  logic [CNT_W-1:0] next_len;

  always_comb begin
    phase_end = (phase_q != PH_IDLE) && (cnt_q == '0);
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    next_len  = '0;
    if (phase_q == PH_IDLE) begin
      if (start_go_i) begin
        phase_d = PH_SETUP;
        cnt_d   = start_count(lens_i[CNT_W-1:0]);
      end
    end else if (phase_end) begin
      phase_d = follow(phase_q, ar_en_q);
      case (phase_d)
        PH_READ:    next_len = len_q[1];
        PH_TURN:    next_len = len_q[2];
        PH_WRITE:   next_len = len_q[3];
        PH_SAMPLE:  next_len = len_q[4];
        PH_AUTORST: next_len = len_q[5];
        default:    next_len = '0;
      endcase
      cnt_d = start_count(next_len);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // capture registers: clock enable is the accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_en_q <= 1'b0;
      for (int k = 0; k < NUM_LEN; k++) len_q[k] <= '0;
    end else if (start_go_i && phase_q == PH_IDLE) begin
      ar_en_q <= autorst_en_i;
      for (int k = 0; k < NUM_LEN; k++) len_q[k] <= lens_i[k*CNT_W +: CNT_W];
    end
  end

  assign phase_o = phase_q;
  assign last_o  = phase_end;

  // R1: turnaround is entered only from read
  assert_turn_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TURN && $past(phase_q) != PH_TURN) |-> $past(phase_q) == PH_READ);
  // R1: write is entered only from turnaround
  assert_write_after_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WRITE && $past(phase_q) != PH_WRITE) |-> $past(phase_q) == PH_TURN);
  // R1: auto-reset is entered only from the readout sample
  assert_autorst_after_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_AUTORST && $past(phase_q) != PH_AUTORST) |-> $past(phase_q) == PH_SAMPLE);
  // R2: a phase holds while its counter has not run out
  assert_phase_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && cnt_q != '0) |=> $stable(phase_q));
endmodule

// File: rtl/tick_status_latch.sv
module tick_status_latch
  import tick_seq_pkg::*;
#(
  parameter int unsigned N_DOM  = 4,
  parameter int unsigned FC_W   = 4,
  parameter int unsigned MASK_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  phase_e                  phase_i,
  input  logic                    last_i,
  input  logic                    start_go_i,
  input  logic                    ovf_i,
  input  logic                    collide_i,
  input  logic [N_DOM*FC_W-1:0]   fire_cnt_i,
  input  logic [N_DOM*MASK_W-1:0] winner_mask_i,
  output logic [31:0]             status_o,
  output logic [MASK_W-1:0]       mask_o
);
  logic [MASK_W-1:0] dom_part [N_DOM];
  logic [MASK_W-1:0] mask_now;
  logic              acc_ovf_q, acc_col_q, acc_ovf_d, acc_col_d;
  logic [31:0]       status_q, status_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              latch_en;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign dom_part[d] = (|fire_cnt_i[d*FC_W +: FC_W]) ?
                         winner_mask_i[d*MASK_W +: MASK_W] : '0;
  end

  always_comb begin
    mask_now = '0;
    for (int d = 0; d < N_DOM; d++) mask_now = mask_now | dom_part[d];
  end

  always_comb begin
    latch_en  = last_i && (phase_i == PH_SAMPLE);
    acc_ovf_d = acc_ovf_q;
    acc_col_d = acc_col_q;
    if (start_go_i && phase_i == PH_IDLE) begin
      acc_ovf_d = 1'b0;
      acc_col_d = 1'b0;
    end else if (phase_i == PH_WRITE) begin
      acc_ovf_d = acc_ovf_q | ovf_i;
      acc_col_d = acc_col_q | collide_i;
    end
    status_d = status_q;
    mask_d   = mask_q;
    if (latch_en) begin
      status_d = {29'd0, acc_col_q, acc_ovf_q, 1'b1};
      mask_d   = mask_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ovf_q <= 1'b0;
      acc_col_q <= 1'b0;
      status_q  <= '0;
      mask_q    <= '0;
    end else begin
      acc_ovf_q <= acc_ovf_d;
      acc_col_q <= acc_col_d;
      status_q  <= status_d;
      mask_q    <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = (phase_i == PH_AUTORST) ? mask_q : '0;

  // R7: the completed flag is set right after the sample phase ends
  assert_status_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_SAMPLE && last_i) |=> status_o[0]);
  // R7: status only changes at the end of a sample phase
  assert_status_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_i == PH_SAMPLE && last_i) |=> $stable(status_o));
endmodule

// File: rtl/tick_sequencer.sv
module tick_sequencer
  import tick_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned N_DOM  = 4,
  parameter int unsigned FC_W   = 4,
  parameter int unsigned MASK_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    params_applied_i,
  input  logic                    dom_rst_req_i,
  input  logic                    param_load_req_i,
  input  logic [CNT_W-1:0]        len_setup_i,
  input  logic [CNT_W-1:0]        len_read_i,
  input  logic [CNT_W-1:0]        len_turn_i,
  input  logic [CNT_W-1:0]        len_write_i,
  input  logic [CNT_W-1:0]        len_sample_i,
  input  logic [CNT_W-1:0]        len_autorst_i,
  input  logic                    autorst_en_i,
  input  logic                    ovf_i,
  input  logic                    collide_i,
  input  logic [N_DOM*FC_W-1:0]   fire_cnt_i,
  input  logic [N_DOM*MASK_W-1:0] winner_mask_i,
  output logic [2:0]              phase_o,
  output logic                    busy_o,
  output logic                    hold_o,
  output logic                    host_drive_o,
  output logic                    array_drive_o,
  output logic                    start_rej_o,
  output logic                    dom_rst_go_o,
  output logic                    param_load_go_o,
  output logic                    cmd_rej_o,
  output logic [31:0]             status_o,
  output logic [MASK_W-1:0]       autorst_mask_o
);
  logic   rst_meta, rst_sync;
  phase_e phase;
  logic   last;
  logic   start_go;
  logic   idle;
  logic [NUM_LEN*CNT_W-1:0] lens;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign lens = {len_autorst_i, len_sample_i, len_write_i,
                 len_turn_i, len_read_i, len_setup_i};
  assign idle = (phase == PH_IDLE);

  tick_cmd_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_sync),
    .idle_i       (idle),
    .start_i      (start_i),
    .applied_i    (params_applied_i),
    .dom_rst_req_i(dom_rst_req_i),
    .load_req_i   (param_load_req_i),
    .start_go_o   (start_go),
    .start_rej_o  (start_rej_o),
    .dom_rst_go_o (dom_rst_go_o),
    .load_go_o    (param_load_go_o),
    .cmd_rej_o    (cmd_rej_o)
  );

  tick_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync),
    .start_go_i  (start_go),
    .lens_i      (lens),
    .autorst_en_i(autorst_en_i),
    .phase_o     (phase),
    .last_o      (last)
  );

  tick_status_latch #(.N_DOM(N_DOM), .FC_W(FC_W), .MASK_W(MASK_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_sync),
    .phase_i      (phase),
    .last_i       (last),
    .start_go_i   (start_go),
    .ovf_i        (ovf_i),
    .collide_i    (collide_i),
    .fire_cnt_i   (fire_cnt_i),
    .winner_mask_i(winner_mask_i),
    .status_o     (status_o),
    .mask_o       (autorst_mask_o)
  );

  always_comb begin
    phase_o       = phase;
    busy_o        = ~idle;
    hold_o        = (phase == PH_SETUP) || (phase == PH_READ);
    host_drive_o  = idle || (phase == PH_SETUP) || (phase == PH_READ);
    array_drive_o = (phase == PH_WRITE);
  end

  // R3: host and array never drive the lanes together
  assert_no_bus_fight_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    !(host_drive_o && array_drive_o));
  // R3: array drive only starts after a dead turnaround cycle
  assert_dead_cycle_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(array_drive_o) |-> ($past(phase_o) == 3'd3 && !$past(host_drive_o)));
  // R8: the mask is quiet outside auto-reset
  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (phase_o != 3'd6) |-> (autorst_mask_o == '0));
endmodule

// File: tb/tb_tick_sequencer.sv
module tb_tick_sequencer;
  localparam int CW = 8, ND = 4, FW = 4, MW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, applied, dreq, lreq, ar_en, ovf, col;
  logic [CW-1:0] l0, l1, l2, l3, l4, l5;
  logic [ND*FW-1:0] fire;
  logic [ND*MW-1:0] win;
  logic [2:0] phase_o;
  logic busy_o, hold_o, host_o, arr_o, srej, dgo, lgo, crej;
  logic [31:0] status_o;
  logic [MW-1:0] mask_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tick_sequencer #(.CNT_W(CW), .N_DOM(ND), .FC_W(FW), .MASK_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .params_applied_i(applied),
    .dom_rst_req_i(dreq), .param_load_req_i(lreq),
    .len_setup_i(l0), .len_read_i(l1), .len_turn_i(l2), .len_write_i(l3),
    .len_sample_i(l4), .len_autorst_i(l5), .autorst_en_i(ar_en),
    .ovf_i(ovf), .collide_i(col), .fire_cnt_i(fire), .winner_mask_i(win),
    .phase_o(phase_o), .busy_o(busy_o), .hold_o(hold_o), .host_drive_o(host_o),
    .array_drive_o(arr_o), .start_rej_o(srej), .dom_rst_go_o(dgo),
    .param_load_go_o(lgo), .cmd_rej_o(crej), .status_o(status_o),
    .autorst_mask_o(mask_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle phase and enable checks (R1, R3, R4, R8, R9)
  task automatic chk_cycle(input int p, input logic [MW-1:0] emask);
    chk("R1 phase", {29'd0, phase_o}, p);
    chk("R3 host drive", {31'd0, host_o}, (p <= 2) ? 1 : 0);
    chk("R3 array drive", {31'd0, arr_o}, (p == 4) ? 1 : 0);
    chk("R4 hold", {31'd0, hold_o}, (p == 1 || p == 2) ? 1 : 0);
    chk("R9 busy", {31'd0, busy_o}, (p != 0) ? 1 : 0);
    chk("R8 mask", {16'd0, mask_o}, (p == 6) ? {16'd0, emask} : 32'd0);
  endtask

  // one full tick; pat bit0 = overflow in write, bit1 = collision in write
  task automatic run_tick(input int ls, input int lr, input int lt, input int lw,
                          input int lm, input int la, input logic en,
                          input int pat, input int seed);
    int len [6];
    logic [MW-1:0] emask;
    len[0] = ls; len[1] = lr; len[2] = lt; len[3] = lw; len[4] = lm; len[5] = la;
    emask = '0;
    for (int d = 0; d < ND; d++) begin
      logic [FW-1:0] fc;
      logic [MW-1:0] wm;
      fc = FW'((seed >> (2*d)) & 3);
      wm = MW'((16'h0001 << ((seed + 5*d) % 16)) | (16'h0100 >> d));
      fire[d*FW +: FW] = fc;
      win[d*MW +: MW] = wm;
      if (fc != 0) emask = emask | wm;
    end
    l0 = CW'(ls); l1 = CW'(lr); l2 = CW'(lt); l3 = CW'(lw); l4 = CW'(lm); l5 = CW'(la);
    ar_en = en;
    start_i = 1'b1;
    ovf = 1'b1; col = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: new lengths after acceptance must not affect this tick
    l0 = 8'd7; l1 = 8'd7; l2 = 8'd7; l3 = 8'd7; l4 = 8'd7; l5 = 8'd7;
    ar_en = ~en;
    for (int p = 1; p <= 6; p++) begin
      int e;
      if (p == 6 && !en) break;
      e = (len[p-1] == 0) ? 1 : len[p-1];
      for (int c = 0; c < e; c++) begin
        chk_cycle(p, emask);
        if (p == 4) begin
          ovf = pat[0] && (c == e - 1);
          col = pat[1] && (c == 0);
        end else begin
          ovf = 1'b1; col = 1'b1;
        end
        @(negedge clk);
      end
    end
    ovf = 1'b0; col = 1'b0;
    chk_cycle(0, emask);
    chk("R7 status", status_o, {29'd0, pat[1], pat[0], 1'b1});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0; start_i = 1'b0; applied = 1'b1; dreq = 1'b0; lreq = 1'b0;
    ar_en = 1'b0; ovf = 1'b0; col = 1'b0; fire = '0; win = '0;
    l0 = 8'd1; l1 = 8'd1; l2 = 8'd1; l3 = 8'd1; l4 = 8'd1; l5 = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 phase", {29'd0, phase_o}, 0);
    chk("R10 host", {31'd0, host_o}, 1);
    chk("R10 array", {31'd0, arr_o}, 0);
    chk("R10 status", status_o, 0);
    chk("R10 pulses", {28'd0, srej, dgo, lgo, crej}, 0);

    // default 10:2:8:1:1 rhythm with auto-reset
    run_tick(10, 2, 8, 1, 1, 1, 1'b1, 3, 27);

    // sweep of lengths, enables and report patterns
    seed = 1;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++)
          for (int w = 0; w < 3; w++)
            for (int m = 0; m < 3; m++)
              for (int r = 0; r < 2; r++)
                for (int en = 0; en < 2; en++) begin
                  run_tick(a, 1 + 2*b, c, (w == 2) ? 4 : w + 1, m, r + 1,
                           en[0], seed % 4, seed * 37);
                  seed++;
                end

    // R5: start refused while configuration not applied
    applied = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; applied = 1'b1;
    chk("R5 not applied reject", {31'd0, srej}, 1);
    chk("R5 not applied stays idle", {29'd0, phase_o}, 0);
    @(negedge clk);
    chk("R5 reject is one cycle", {31'd0, srej}, 0);

    // R5/R6: start and load during a tick are refused
    l0 = 8'd2; l1 = 8'd2; l2 = 8'd2; l3 = 8'd2; l4 = 8'd2; l5 = 8'd2; ar_en = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; lreq = 1'b1;
    @(negedge clk);
    start_i = 1'b0; lreq = 1'b0;
    chk("R5 mid-tick start reject", {31'd0, srej}, 1);
    chk("R6 mid-tick cmd reject", {31'd0, crej}, 1);
    chk("R6 mid-tick no load go", {31'd0, lgo}, 0);
    chk("R5 tick continues", {29'd0, phase_o}, 2);
    for (int k = 0; k < 40 && phase_o != 3'd0; k++) @(negedge clk);
    chk("R5 tick ended", {29'd0, phase_o}, 0);

    // R6: commands accepted while idle
    lreq = 1'b1;
    @(negedge clk);
    lreq = 1'b0;
    chk("R6 idle load go", {31'd0, lgo}, 1);
    chk("R6 idle load no reject", {31'd0, crej}, 0);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    chk("R6 idle domain reset go", {31'd0, dgo}, 1);
    @(negedge clk);
    chk("R6 go is one cycle", {31'd0, dgo}, 0);

    // R6: command in the same cycle as an accepted start is refused
    dreq = 1'b1; start_i = 1'b1;
    @(negedge clk);
    dreq = 1'b0; start_i = 1'b0;
    chk("R6 same-cycle reject", {31'd0, crej}, 1);
    chk("R6 same-cycle no go", {31'd0, dgo}, 0);
    chk("R5 same-cycle start accepted", {29'd0, phase_o}, 1);
    for (int k = 0; k < 40 && phase_o != 3'd0; k++) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule